// File: doc/BRIEF.md
# Sequence-Keyed Signature Controller

This block is a small four-state controller with a registered state and an output decoded from that state. Its state graph has a second layer on top. The controller needs only a 2-bit command, and every command it uses has a defined transition. To make room for a second layer, the input bus carries one extra bit. Any code with that bit set is a free slot that the host graph never uses, and in such a slot the host state simply holds.

A fixed secret sequence of six such free codes, applied from one particular host state, walks a hidden path. At each step of that path the output port shows one word of a stored signature. The signature is held already encrypted, so the words mean nothing without the key kept off-chip. Both the sequence and the signature are parameters.

Any command the host graph uses behaves exactly as in the plain controller. Leaving the path at any point puts the machine back under its normal graph.

Top module: `wm_ctrl`

## Requirements
- R1: During and right after synchronous reset, the host state is 0 and the output shows the host code of state 0, which is 4'b0001.
- R2: With the extra input bit (din[2]) at 0, din[1:0] selects the next host state at the next clock edge: 00 holds, 01 moves to (state+1) mod 4, 10 moves to (state-1) mod 4, and 11 goes to state 0.
- R3: When no signature word is being shown, the output is one-hot, with bit s set for host state s.
- R4: Any input with din[2]=1 that is not accepted as a path step leaves the host state unchanged, and the output shows that state's host code.
- R5: From host state 2, input {1, 2'b10} starts the path, and on the next cycle the output shows signature word 0, which is 4'hA.
- R6: The path step codes for din[1:0] are 10, 01, 11, 00, 01, 10, each applied with din[2]=1. The signature words are A, 3, C, 5, E, 7. After step k (counting from 0) is accepted, the output shows word k. After the sixth step it shows 4'h7.
- R7: A wrong input in the middle of the path ends it. The next cycle shows the host code of the state the normal graph gives for that input: the R2 transition when din[2]=0, or a hold when din[2]=1. The one exception is an input equal to the first step code while the machine is in state 2, which starts the path again at word 0.
- R8: After the sixth word, any input other than a fresh start returns the output to the host code.
- R9: The first step code applied in any host state other than 2 is ignored: the state holds and the host code is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 3 | Bits [1:0] are the host command; bit 2 is the augmentation bit that opens the free codes |
| dout | output | 4 | Host state code, or a signature word while on the hidden path |

## Verification
Two things can happen on the same clock edge: the hidden path breaks off, and a new path starts or the host state moves. A first-step code applied in the middle of the path, or right after the sixth word, must both end the current walk and restart at word 0. A functional command applied in the middle of the path must end the walk and move the host state in that same edge. The bench provokes these edges with directed break-offs at every step depth, and with random input biased toward the step codes. Each output is compared one cycle later with a bench model of the host graph and the path counter.

// File: rtl/wm_ctrl.sv
module wm_ctrl #(
  parameter int ST_W = 2,
  parameter int OUT_W = 4,
  parameter int WM_LEN = 6,
  parameter logic [1:0] WM_ENTRY = 2'd2,
  parameter logic [2*WM_LEN-1:0] WM_SEQ = 12'h936,
  parameter logic [OUT_W*WM_LEN-1:0] WM_SIG = 24'h7E5C3A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   din,
  output logic [OUT_W-1:0] dout
);
  localparam int FIN_W = 2;
  localparam int CNT_W = $clog2(WM_LEN + 1);

  logic [ST_W-1:0]  st, st_nx;
  logic [CNT_W-1:0] step, step_nx;

  wire             aug = din[FIN_W];
  wire [FIN_W-1:0] fin = din[FIN_W-1:0];

  wire go_on  = aug && (step != '0) && (int'(step) < WM_LEN) &&
                (fin == WM_SEQ[int'(step)*FIN_W +: FIN_W]);
  wire go_new = aug && (st == ST_W'(WM_ENTRY)) && (fin == WM_SEQ[FIN_W-1:0]);

  assign step_nx = go_on ? step + CNT_W'(1) : (go_new ? CNT_W'(1) : '0);

  always_comb begin
    st_nx = st;
    if (!aug) begin
      case (fin)
        2'b01:   st_nx = st + ST_W'(1);
        2'b10:   st_nx = st - ST_W'(1);
        2'b11:   st_nx = '0;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= '0;
      step <= '0;
    end else begin
      st   <= st_nx;
      step <= step_nx;
    end
  end

  wire [OUT_W-1:0] host_code = OUT_W'(1) << st;
  assign dout = (step == '0) ? host_code
                             : WM_SIG[(int'(step) - 1)*OUT_W +: OUT_W];

  p_plain_out_r3: assert property (@(posedge clk) disable iff (rst)
    !din[FIN_W] |=> ($countones(dout) == 1));

  p_aug_holds_r4: assert property (@(posedge clk) disable iff (rst)
    din[FIN_W] |=> $stable(st));

  p_step_bound_r6: assert property (@(posedge clk) disable iff (rst)
    int'(step) <= WM_LEN);

  p_path_at_entry_r9: assert property (@(posedge clk) disable iff (rst)
    (step != '0) |-> (st == ST_W'(WM_ENTRY)));

  p_break_r7: assert property (@(posedge clk) disable iff (rst)
    !din[FIN_W] |=> (step == '0));
endmodule

// File: tb/wm_ctrl_bench.sv
module wm_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] din = 3'b000;
  logic [3:0] dout;

  wm_ctrl u_wm_ctrl (.clk(clk), .rst(rst), .din(din), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [1:0] SEQ_TBL [6] = '{2'b10, 2'b01, 2'b11, 2'b00, 2'b01, 2'b10};
  localparam logic [3:0] SIG_TBL [6] = '{4'hA, 4'h3, 4'hC, 4'h5, 4'hE, 4'h7};

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  int m_st = 0;
  int m_step = 0;

  function automatic logic [3:0] exp_out(input int s, input int k);
    return (k == 0) ? (4'b0001 << s) : SIG_TBL[k-1];
  endfunction

  task automatic check(input string tag);
    logic [3:0] e;
    e = exp_out(m_st, m_step);
    n_vec++;
    if (dout !== e) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected=%h (state %0d step %0d)", tag, dout, e, m_st, m_step);
    end
  endtask

  task automatic apply(input logic [2:0] v, input string tag);
    bit aug, on, nw;
    din = v;
    aug = v[2];
    on  = aug && m_step != 0 && m_step < 6 && v[1:0] == SEQ_TBL[m_step];
    nw  = aug && m_st == 2 && v[1:0] == SEQ_TBL[0];
    m_step = on ? m_step + 1 : (nw ? 1 : 0);
    if (!aug) begin
      case (v[1:0])
        2'b01: m_st = (m_st + 1) % 4;
        2'b10: m_st = (m_st + 3) % 4;
        2'b11: m_st = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic goto_entry();
    apply(3'b011, "R2");
    apply(3'b001, "R2");
    apply(3'b001, "R2");
  endtask

  task automatic walk(input int n, input string tag);
    for (int i = 0; i < n; i++) apply({1'b1, SEQ_TBL[i]}, tag);
  endtask

  function automatic string finish_line();
    return $sformatf("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%s", finish_line());
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    @(negedge clk);
    check("R1");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1");

    apply(3'b001, "R2");
    apply(3'b001, "R2");
    apply(3'b000, "R2");
    apply(3'b010, "R2");
    apply(3'b011, "R2");
    apply(3'b010, "R2");
    apply(3'b001, "R3");

    apply({1'b1, SEQ_TBL[0]}, "R9");
    apply(3'b111, "R4");
    apply(3'b101, "R4");

    goto_entry();
    walk(1, "R5");
    for (int i = 1; i < 6; i++) apply({1'b1, SEQ_TBL[i]}, "R6");
    apply(3'b100, "R8");
    apply(3'b000, "R8");

    walk(6, "R6");
    walk(1, "R8");
    apply(3'b001, "R7");

    for (int k = 1; k < 6; k++) begin
      goto_entry();
      walk(k, "R6");
      apply(3'b001, "R7");
      goto_entry();
      walk(k, "R6");
      apply({1'b1, ~SEQ_TBL[k]}, "R7");
      goto_entry();
      walk(k, "R6");
      apply({1'b1, SEQ_TBL[0]}, "R7");
    end

    for (int i = 0; i < 400; i++) apply({1'b0, 2'($urandom)}, "R2");

    for (int i = 0; i < 2000; i++) begin
      logic [2:0] v;
      int r;
      r = $urandom_range(0, 9);
      if (r < 4 && m_step < 6) v = {1'b1, SEQ_TBL[m_step]};
      else v = 3'($urandom);
      apply(v, "R7");
    end

    finished = 1;
    $display("%s", finish_line());
    $finish;
  end
endmodule